// File: doc/BRIEF.md
# Per-CPU Level-1 Interrupt Aggregator

This block gathers a parameterised set of level-sensitive interrupt sources and turns them into one interrupt line per CPU. The sources come in groups of 32, one group per register word. Each CPU has its own register window. Software uses the enable words in that window to choose which sources may interrupt that CPU. A CPU's line is raised while at least one source is both active and enabled for that CPU. Because every CPU keeps its own enable copy, a source can go to one CPU, to both, or to neither.

The register bus is simple: byte address, write strobe, write data and read data. It finishes every access in the same cycle, and read data is combinational from the address. Inside a window the enable words come first and the read-only status words come after them. The windows of the CPUs are packed back to back. Inside each group the word order is reversed, so the lowest address holds the highest-numbered sources. Status words give the live level of the source inputs.

Top module: `l1_irq_ctrl`

## Requirements
- R1: After a synchronous reset every enable bit is zero. Every irq_o bit is low and stays low whatever the sources do until an enable word is written.
- R2: A write to an enable word replaces all 32 bits of that word, and a later read of that word returns the value written.
- R3: The word address is bus_addr[ADDR_W-1:2], and bits [1:0] are not decoded. With W = 2*NUM_WORDS words per window, CPU c's enable word g (g from 0 to NUM_WORDS-1) is at byte offset (c*W + g)*4, and its status word g is at (c*W + NUM_WORDS + g)*4. Word g in either group covers sources (NUM_WORDS-1-g)*32 to (NUM_WORDS-1-g)*32+31, and bit b of that word is source (NUM_WORDS-1-g)*32+b.
- R4: A status word reads the current level of its 32 source inputs. Writes to status offsets change no enable bit.
- R5: irq_o[c] is a register that holds the OR over all sources of (source level AND CPU c's enable bit). It reflects a change in a source or in an enable bit at the first rising clock edge after the change has settled.
- R6: The enable copies of the CPUs are independent. A write into one CPU's window leaves every other CPU's enables and interrupt line unaffected.
- R7: A byte address at or above NUM_CPUS*2*NUM_WORDS*4 reads as zero and changes no enable bit when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_i | input | NUM_WORDS*32 | Level-sensitive interrupt sources, bit n is source n |
| irq_o | output | NUM_CPUS | Interrupt line per CPU, registered |

## Verification
A wrong enable bit shows up in two places. The readback of its word is off straight away, and the affected CPU's line is wrong one edge after the matching source goes active. The bench therefore checks each enable word by reading it and also walks a single active source across every source position for each CPU. The walk confirms the reversed word mapping, the one-cycle lag in both directions and the absence of leakage to the other CPU. A decoder fault that sends a status write, an out-of-range write or a write for another CPU into the enable storage is caught at the next readback of the enable words.

// File: rtl/l1_irq_pkg.sv
package l1_irq_pkg;

    localparam int SRC_PER_WORD = 32;

    typedef logic [SRC_PER_WORD-1:0] word_t;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_STATUS = 2'd2
    } reg_kind_e;

    // Group word index to source word index (reversed order).
    function automatic int grp_to_src_word(input int grp, input int nwords);
        return nwords - 1 - grp;
    endfunction

endpackage

// File: rtl/l1_irq_decode.sv
module l1_irq_decode
    import l1_irq_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 8,
    parameter int GRP_W     = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output reg_kind_e           kind,
    output logic [NUM_CPUS-1:0] cpu_sel,
    output logic [GRP_W-1:0]    grp
);
    localparam int WIN_WORDS   = 2 * NUM_WORDS;
    localparam int TOTAL_WORDS = NUM_CPUS * WIN_WORDS;

    logic [ADDR_W-3:0] waddr;
    assign waddr = addr[ADDR_W-1:2];

    always_comb begin
        int wa;
        int ci;
        int off;
        wa      = int'(waddr);
        ci      = 0;
        off     = 0;
        kind    = REG_NONE;
        cpu_sel = '0;
        grp     = '0;
        if (wa < TOTAL_WORDS) begin
            ci  = wa / WIN_WORDS;
            off = wa % WIN_WORDS;
            for (int i = 0; i < NUM_CPUS; i++) begin
                cpu_sel[i] = (ci == i);
            end
            if (off < NUM_WORDS) begin
                kind = REG_ENABLE;
                grp  = GRP_W'(off);
            end else begin
                kind = REG_STATUS;
                grp  = GRP_W'(off - NUM_WORDS);
            end
        end
    end

endmodule

// File: rtl/l1_irq_bank.sv
module l1_irq_bank
    import l1_irq_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int GRP_W     = 1,
    localparam int NSRC     = NUM_WORDS * SRC_PER_WORD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] grp,
    input  word_t            wdata,
    input  logic [NSRC-1:0]  src_i,
    output logic [NSRC-1:0]  en_o,
    output logic             irq_o
);
    word_t en_q [NUM_WORDS];
    word_t pend [NUM_WORDS];
    logic  [NUM_WORDS-1:0] word_hit;
    logic  irq_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int GRP_OF_W = grp_to_src_word(w, NUM_WORDS);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[w] <= '0;
            end else if (wr_en && (grp == GRP_W'(GRP_OF_W))) begin
                en_q[w] <= wdata;
            end
        end

        assign en_o[w*SRC_PER_WORD +: SRC_PER_WORD] = en_q[w];
        assign pend[w]     = src_i[w*SRC_PER_WORD +: SRC_PER_WORD] & en_q[w];
        assign word_hit[w] = |pend[w];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |word_hit;
    end

    assign irq_o = irq_q;

    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|src_i)); // R5
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|en_o)); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en_o)); // R2

endmodule

// File: rtl/l1_irq_ctrl.sv
module l1_irq_ctrl
    import l1_irq_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 8,
    localparam int NSRC     = NUM_WORDS * SRC_PER_WORD,
    localparam int GRP_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NSRC-1:0]     src_i,
    output logic [NUM_CPUS-1:0] irq_o
);
    reg_kind_e            kind;
    logic [NUM_CPUS-1:0]  cpu_sel;
    logic [GRP_W-1:0]     grp;
    logic [NUM_CPUS-1:0]  bank_wr;
    logic [NSRC-1:0]      en_all [NUM_CPUS];

    l1_irq_decode #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_CPUS  (NUM_CPUS),
        .ADDR_W    (ADDR_W),
        .GRP_W     (GRP_W)
    ) u_dec (
        .addr    (bus_addr),
        .kind    (kind),
        .cpu_sel (cpu_sel),
        .grp     (grp)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign bank_wr[c] = bus_wr && cpu_sel[c] && (kind == REG_ENABLE);

        l1_irq_bank #(
            .NUM_WORDS (NUM_WORDS),
            .GRP_W     (GRP_W)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bank_wr[c]),
            .grp   (grp),
            .wdata (bus_wdata),
            .src_i (src_i),
            .en_o  (en_all[c]),
            .irq_o (irq_o[c])
        );

        AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && kind == REG_STATUS) |=> $stable(en_all[c])); // R4
        AST_OOR_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && kind == REG_NONE) |=> $stable(en_all[c])); // R7
        AST_OTHER_CPU_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && !cpu_sel[c]) |=> $stable(en_all[c])); // R6
    end

    always_comb begin
        int sw;
        sw        = grp_to_src_word(int'(grp), NUM_WORDS);
        bus_rdata = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (cpu_sel[c]) begin
                case (kind)
                    REG_ENABLE: bus_rdata = en_all[c][sw*SRC_PER_WORD +: SRC_PER_WORD];
                    REG_STATUS: bus_rdata = src_i[sw*SRC_PER_WORD +: SRC_PER_WORD];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0)); // R1
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (kind == REG_NONE) |-> (bus_rdata == '0)); // R7
    AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cpu_sel)); // R6

endmodule

// File: tb/sim_l1_irq_ctrl.sv
module sim_l1_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BNW  = 4;
    localparam int BNC  = 2;
    localparam int BAW  = 8;
    localparam int NSRC = BNW * 32;
    localparam int WIN  = 2 * BNW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [BAW-1:0]  addr = '0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NSRC-1:0] src = '0;
    logic [BNC-1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [31:0] en_m [BNC][BNW];

    always #(CLK_PERIOD/2) clk = ~clk;

    l1_irq_ctrl #(.NUM_WORDS(BNW), .NUM_CPUS(BNC), .ADDR_W(BAW)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .src_i(src), .irq_o(irq)
    );

    function automatic int en_addr(int c, int g);
        return (c*WIN + g) * 4;
    endfunction
    function automatic int st_addr(int c, int g);
        return (c*WIN + BNW + g) * 4;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int a, logic [31:0] d);
        @(negedge clk);
        addr = BAW'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(int a, output logic [31:0] d);
        addr = BAW'(a);
        #1;
        d = rdata;
    endtask

    task automatic check_all_en(string req);
        logic [31:0] v;
        for (int c = 0; c < BNC; c++)
            for (int g = 0; g < BNW; g++) begin
                rd_reg(en_addr(c, g), v);
                check(req, v, en_m[c][BNW-1-g]);
            end
    endtask

    function automatic logic exp_irq(int c);
        logic r;
        r = 1'b0;
        for (int w = 0; w < BNW; w++)
            r = r | (|(src[w*32 +: 32] & en_m[c][w]));
        return r;
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < BNC; c++)
            for (int w = 0; w < BNW; w++) en_m[c][w] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq after reset", 32'(irq), 32'h0);
        check_all_en("R1 enables after reset");
        src = '1;
        repeat (2) @(negedge clk);
        check("R1 irq with all sources and no enables", 32'(irq), 32'h0);
        src = '0;

        // R2 / R6: full-word replace and per-CPU independence
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < BNC; c++)
                for (int g = 0; g < BNW; g++) begin
                    v = 32'h9E3779B9 * (c*16 + g + k*7 + 1);
                    if (k == 1 && g == 0) v = 32'h0000FFFF;
                    wr_reg(en_addr(c, g), v);
                    en_m[c][BNW-1-g] = v;
                    check_all_en("R2 R6 enable readback");
                end

        // R3 / R4 / R5: status view and irq for several source patterns
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            for (int w = 0; w < BNW; w++)
                src[w*32 +: 32] = (k == 5) ? 32'h0 : 32'h85EBCA6B * (k*5 + w + 1) >> k*6;
            @(negedge clk);
            @(negedge clk);
            for (int c = 0; c < BNC; c++) begin
                for (int g = 0; g < BNW; g++) begin
                    rd_reg(st_addr(c, g), v);
                    check("R3 R4 status word", v, src[(BNW-1-g)*32 +: 32]);
                end
                check("R5 irq vs pattern", 32'(irq[c]), 32'(exp_irq(c)));
            end
        end

        // R4: status writes ignored
        src = {BNW{32'hC0FFEE11}};
        for (int c = 0; c < BNC; c++)
            for (int g = 0; g < BNW; g++)
                wr_reg(st_addr(c, g), 32'hDEADBEEF ^ g);
        check_all_en("R4 enables after status writes");
        for (int g = 0; g < BNW; g++) begin
            rd_reg(st_addr(1, g), v);
            check("R4 status after writes", v, 32'hC0FFEE11);
        end

        // R7: out-of-range space
        for (int a = BNC*WIN*4; a < (1 << BAW); a += 4) begin
            wr_reg(a, 32'hFFFFFFFF);
            rd_reg(a, v);
            check("R7 out-of-range read", v, 32'h0);
        end
        check_all_en("R7 enables after out-of-range writes");

        // R3 / R5 / R6: walk one source over every position for each CPU
        src = '0;
        for (int c = 0; c < BNC; c++)
            for (int g = 0; g < BNW; g++) begin
                wr_reg(en_addr(c, g), 32'h0);
                en_m[c][BNW-1-g] = '0;
            end
        for (int s = 0; s < NSRC; s++)
            for (int c = 0; c < BNC; c++) begin
                src = '0;
                src[s] = 1'b1;
                wr_reg(en_addr(c, BNW-1-s/32), 32'h1 << (s % 32));
                check("R5 enable lag", 32'(irq), 32'h0);
                @(negedge clk);
                check("R3 R5 routed irq", 32'(irq[c]), 32'h1);
                check("R6 other cpu quiet", 32'(irq[1-c]), 32'h0);
                src = '0;
                #1;
                check("R5 source drop lag", 32'(irq[c]), 32'h1);
                @(negedge clk);
                check("R5 source drop", 32'(irq), 32'h0);
                wr_reg(en_addr(c, BNW-1-s/32), 32'h0);
            end

        report();
    end

endmodule